// File: doc/BRIEF.md
# LCD Row Scan Timing Generator

This block produces the row-by-row scan timing for a dot-matrix LCD driver that holds its picture in an on-chip display RAM. Each oscillator tick moves a row counter forward by one row. On that same tick, a wide segment latch is loaded with the RAM word for the new row, and a one-hot common select marks the row being driven. A line-offset input picks which RAM line is shown on the first scanned row. This allows vertical scrolling without rewriting the RAM.

A single chip scans 16 rows. Two chips can be cascaded to scan 32 rows. The master runs the 32-row count, drives commons for rows 0 to 15, and drives the alternating-polarity frame signal. The slave drives rows 16 to 31. It keeps its own count aligned by watching every edge of the frame signal it receives. The RAM read port is asynchronous: the block presents an address and takes the word back in the same cycle.

Top module: `lcd_scan_timing`

## Requirements
- R1: While `rstN` is low, `comSel` is all zero, `segData` is all zero and `frameOut` is low.
- R2: The first `scanTick` after reset selects row 0. Each later `scanTick` advances exactly one row. At most one bit of `comSel` is ever high.
- R3: A master with `dualChip` low scans rows 0..15: bit k of `comSel` is high on row k, and the tick after row 15 returns to row 0.
- R4: A master with `dualChip` high scans rows 0..31. It drives bit k on row k for rows 0..15, and `comSel` is zero on rows 16..31.
- R5: A slave (`isMaster` low) always scans 32 rows. Bit k of `comSel` is high on row 16+k, and `comSel` is zero on rows 0..15.
- R6: For row r, `segData` holds the RAM word at address (r + `linePreset`) mod 32. It is loaded on the same clock edge that updates `comSel` for that row.
- R7: On a master, `frameOut` inverts on the tick that wraps from the last row to row 0, and on no other clock edge.
- R8: On a slave, a clock edge where `frameIn` differs from its value at the previous edge forces the row to 0 at that edge. This takes priority over a coincident `scanTick`.
- R9: `frameOe` equals `isMaster`. On a slave, `frameOut` stays low.
- R10: Without `scanTick` (and, on a slave, without a frame edge), `comSel` and `segData` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| scanTick | input | 1 | One-cycle pulse from the oscillator divider; advances the scan |
| isMaster | input | 1 | 1 = master or single chip, 0 = cascade slave |
| dualChip | input | 1 | On a master, 1 selects the 32-row cascade scan |
| linePreset | input | 5 | RAM line shown on row 0 |
| frameIn | input | 1 | Frame signal received from the master (used when slave) |
| ramData | input | 61 | Display RAM word at `ramAddr` |
| ramAddr | output | 5 | RAM line for the row about to be loaded |
| segData | output | 61 | Latched segment data of the current row |
| comSel | output | 16 | One-hot common select |
| frameOut | output | 1 | Frame polarity signal driven by the master |
| frameOe | output | 1 | Output enable for the frame pin |

## Verification
A frame edge seen by the slave and an oscillator tick can both land on the same clock edge. In that case both try to load the row counter and the segment latch. The bench runs a slave to row 20, then toggles `frameIn` in the same cycle as a `scanTick`. It expects the row to go to 0, not to 21. This shows as `comSel` becoming zero and `segData` taking the word at line 0 plus the offset. Sixteen further ticks must then bring up bit 0 of `comSel`, which confirms the counter restarted from the resynchronised row.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  localparam int ROW_W = 5;

  typedef struct packed {
    logic             load;
    logic [ROW_W-1:0] nextRow;
  } scan_ctl_t;
endpackage

// File: rtl/lcd_scan_ctrl.sv
module lcd_scan_ctrl
  import lcd_scan_pkg::*;
#(
  parameter int COM_N = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             scanTick,
  input  logic             isMaster,
  input  logic             dualChip,
  input  logic             frameIn,
  output scan_ctl_t        ctl,
  output logic [ROW_W-1:0] curRow,
  output logic             frameQ
);
  localparam int ROWS = 2 * COM_N;
  localparam logic [ROW_W-1:0] LAST_SINGLE = ROW_W'(COM_N - 1);
  localparam logic [ROW_W-1:0] LAST_DUAL   = ROW_W'(ROWS - 1);

  logic             running;
  logic             frameSeen;
  logic [ROW_W-1:0] row;
  logic [ROW_W-1:0] lastRow;
  logic [ROW_W-1:0] stepRow;
  logic             resync;
  logic             wrapHit;
  logic             flipFrame;

  always_comb begin
    lastRow     = (isMaster && !dualChip) ? LAST_SINGLE : LAST_DUAL;
    wrapHit     = running && (row == lastRow);
    stepRow     = (!running || wrapHit) ? '0 : row + 1'b1;
    resync      = !isMaster && (frameIn != frameSeen);
    flipFrame   = scanTick && isMaster && wrapHit;
    ctl.load    = resync || scanTick;
    ctl.nextRow = resync ? '0 : stepRow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      row       <= '0;
      running   <= 1'b0;
      frameSeen <= 1'b0;
      frameQ    <= 1'b0;
    end else begin
      frameSeen <= frameIn;
      if (ctl.load) begin
        row     <= ctl.nextRow;
        running <= 1'b1;
      end
      if (flipFrame) frameQ <= ~frameQ;
    end
  end

  assign curRow = row;

  assert_frame_flip_R7: assert property (@(posedge clk) disable iff (!rstN)
    flipFrame |=> (frameQ != $past(frameQ)));
  assert_frame_still_R7: assert property (@(posedge clk) disable iff (!rstN)
    !flipFrame |=> $stable(frameQ));
  assert_resync_row_R8: assert property (@(posedge clk) disable iff (!rstN)
    resync |=> (row == '0));
endmodule

// File: rtl/lcd_scan_datapath.sv
module lcd_scan_datapath
  import lcd_scan_pkg::*;
#(
  parameter int SEG_W = 61,
  parameter int COM_N = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             isMaster,
  input  scan_ctl_t        ctl,
  input  logic [ROW_W-1:0] linePreset,
  input  logic [SEG_W-1:0] ramData,
  output logic [ROW_W-1:0] ramAddr,
  output logic [SEG_W-1:0] segData,
  output logic [COM_N-1:0] comSel
);
  localparam logic [ROW_W-1:0] SLAVE_BASE = ROW_W'(COM_N);

  logic [ROW_W-1:0] winBase;
  logic [ROW_W-1:0] winOffs;
  logic             inWin;
  logic [COM_N-1:0] selNext;

  assign ramAddr = ctl.nextRow + linePreset;
  assign winBase = isMaster ? '0 : SLAVE_BASE;
  assign winOffs = ctl.nextRow - winBase;
  assign inWin   = (winOffs < SLAVE_BASE);

  for (genvar k = 0; k < COM_N; k++) begin : g_sel
    assign selNext[k] = inWin && (winOffs == ROW_W'(k));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      segData <= '0;
      comSel  <= '0;
    end else if (ctl.load) begin
      segData <= ramData;
      comSel  <= selNext;
    end
  end

  assert_onehot_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(comSel));
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> ($stable(comSel) && $stable(segData)));
endmodule

// File: rtl/lcd_scan_timing.sv
module lcd_scan_timing
  import lcd_scan_pkg::*;
#(
  parameter int SEG_W = 61,
  parameter int COM_N = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             scanTick,
  input  logic             isMaster,
  input  logic             dualChip,
  input  logic [ROW_W-1:0] linePreset,
  input  logic             frameIn,
  input  logic [SEG_W-1:0] ramData,
  output logic [ROW_W-1:0] ramAddr,
  output logic [SEG_W-1:0] segData,
  output logic [COM_N-1:0] comSel,
  output logic             frameOut,
  output logic             frameOe
);
  scan_ctl_t        ctl;
  logic [ROW_W-1:0] curRow;
  logic             frameQ;

  lcd_scan_ctrl #(.COM_N(COM_N)) u_ctrl (
    .clk(clk), .rstN(rstN), .scanTick(scanTick), .isMaster(isMaster),
    .dualChip(dualChip), .frameIn(frameIn), .ctl(ctl), .curRow(curRow),
    .frameQ(frameQ)
  );

  lcd_scan_datapath #(.SEG_W(SEG_W), .COM_N(COM_N)) u_data (
    .clk(clk), .rstN(rstN), .isMaster(isMaster), .ctl(ctl),
    .linePreset(linePreset), .ramData(ramData), .ramAddr(ramAddr),
    .segData(segData), .comSel(comSel)
  );

  assign frameOut = isMaster & frameQ;
  assign frameOe  = isMaster;

  // R4 and R5: a live common must belong to this chip's half of the scan
  assert_window_R4: assert property (@(posedge clk) disable iff (!rstN)
    (comSel != '0) |-> (isMaster ? (curRow < ROW_W'(COM_N)) : (curRow >= ROW_W'(COM_N))));
  assert_slave_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    !isMaster |-> !frameOut);
endmodule

// File: tb/lcd_scan_timing_test.sv
module lcd_scan_timing_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        scanTick = 1'b0;
  logic        isMaster = 1'b1;
  logic        dualChip = 1'b0;
  logic [4:0]  linePreset = '0;
  logic        frameIn = 1'b0;
  logic [60:0] ramData;
  logic [4:0]  ramAddr;
  logic [60:0] segData;
  logic [15:0] comSel;
  logic        frameOut;
  logic        frameOe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [60:0] ramWord(input logic [4:0] a);
    return {{12{a}}, 1'b1};
  endfunction

  assign ramData = ramWord(ramAddr);

  lcd_scan_timing uut (
    .clk(clk), .rstN(rstN), .scanTick(scanTick), .isMaster(isMaster),
    .dualChip(dualChip), .linePreset(linePreset), .frameIn(frameIn),
    .ramData(ramData), .ramAddr(ramAddr), .segData(segData),
    .comSel(comSel), .frameOut(frameOut), .frameOe(frameOe)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reset with a chosen role; checks R1 and R9 during reset
  task automatic doReset(input logic master, input logic dual, input logic [4:0] preset);
    @(negedge clk);
    rstN = 1'b0; scanTick = 1'b0; frameIn = 1'b0;
    isMaster = master; dualChip = dual; linePreset = preset;
    repeat (2) @(negedge clk);
    chk("R1 comSel in reset", 64'(comSel), 64'd0);
    chk("R1 segData in reset", 64'(segData), 64'd0);
    chk("R1 frameOut in reset", 64'(frameOut), 64'd0);
    chk("R9 frameOe", 64'(frameOe), 64'(master));
    rstN = 1'b1;
  endtask

  // One tick pulse; sampled at the following negedge
  task automatic tick();
    scanTick = 1'b1;
    @(negedge clk);
    scanTick = 1'b0;
  endtask

  task automatic testSingle();
    doReset(1'b1, 1'b0, 5'd0);
    @(negedge clk);
    for (int r = 0; r < 16; r++) begin
      tick();
      chk("R3 single row select", 64'(comSel), 64'(16'd1 << r));
      chk("R6 single row data", 64'(segData), 64'(ramWord(5'(r))));
      chk("R7 no flip mid frame", 64'(frameOut), 64'd0);
    end
    tick();
    chk("R3 wrap to row 0", 64'(comSel), 64'd1);
    chk("R7 flip at wrap", 64'(frameOut), 64'd1);
  endtask

  task automatic testHold();
    logic [15:0] c0;
    logic [60:0] s0;
    c0 = comSel; s0 = segData;
    repeat (5) @(negedge clk);
    chk("R10 comSel held", 64'(comSel), 64'(c0));
    chk("R10 segData held", 64'(segData), 64'(s0));
    chk("R7 frame held idle", 64'(frameOut), 64'd1);
  endtask

  task automatic testPreset();
    doReset(1'b1, 1'b0, 5'd30);
    @(negedge clk);
    tick();
    chk("R2 first tick row 0", 64'(comSel), 64'd1);
    chk("R6 preset row 0", 64'(segData), 64'(ramWord(5'd30)));
    tick();
    chk("R6 preset row 1", 64'(segData), 64'(ramWord(5'd31)));
    tick();
    chk("R6 preset wraps mod 32", 64'(segData), 64'(ramWord(5'd0)));
    chk("R2 row 2 select", 64'(comSel), 64'd4);
  endtask

  task automatic testDual();
    doReset(1'b1, 1'b1, 5'd3);
    @(negedge clk);
    for (int r = 0; r < 32; r++) begin
      tick();
      chk("R4 dual row select", 64'(comSel), (r < 16) ? 64'(16'd1 << r) : 64'd0);
      chk("R6 dual row data", 64'(segData), 64'(ramWord(5'(r + 3))));
      chk("R7 dual no early flip", 64'(frameOut), 64'd0);
    end
    tick();
    chk("R4 dual wrap row 0", 64'(comSel), 64'd1);
    chk("R7 dual flip at wrap", 64'(frameOut), 64'd1);
  endtask

  task automatic testSlave();
    doReset(1'b0, 1'b0, 5'd0);
    @(negedge clk);
    for (int r = 0; r <= 20; r++) begin
      tick();
      chk("R5 slave row select", 64'(comSel), (r >= 16) ? 64'(16'd1 << (r - 16)) : 64'd0);
      chk("R9 slave frame low", 64'(frameOut), 64'd0);
    end
    // frame edge and tick in the same cycle: resync wins
    frameIn = 1'b1;
    tick();
    chk("R8 resync comSel", 64'(comSel), 64'd0);
    chk("R8 resync data row 0", 64'(segData), 64'(ramWord(5'd0)));
    for (int r = 1; r <= 16; r++) tick();
    chk("R8 count from resync", 64'(comSel), 64'd1);
    chk("R5 slave row 16 data", 64'(segData), 64'(ramWord(5'd16)));
    chk("R9 slave frameOe", 64'(frameOe), 64'd0);
  endtask

  initial begin
    testSingle();
    testHold();
    testPreset();
    testDual();
    testSlave();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule